// File: doc/BRIEF.md
# IOMMU Translation Lookaside Buffer

This block caches the results of I/O page-table walks so that repeated device accesses to the same page skip the walk. A lookup carries an address-space identifier, an input virtual address, a two-bit page granule code and a write flag. One clock later the block answers with hit or miss. On a hit it returns the translated address (the cached page base plus the request's offset inside the page), the page mask, and a permission fault when a write reaches a page that does not allow writes.

After a miss, the external walker writes its result through the fill port. A walk that failed is marked on that port and leaves the cache unchanged. When the cache is full, a fill clears every entry and then stores the new one. It does not pick a single victim. An invalidation port clears the whole cache, one identifier's entries, or one identifier/page pair. The command that names only an address is widened to a full clear. Two free-running counters record lookup hits and misses.

The cache is fully associative. Each entry holds a valid bit, the identifier, the granule-aligned page address, the granule code, the aligned output base and a write-permission bit. All entries are compared in parallel.

Top module: `iotlb_cache`

## Requirements
- R1: After reset no response is flagged (`rsp_valid`=0), both counters read 0, and every lookup misses until a fill is made.
- R2: A lookup presented in cycle n is answered with `rsp_valid`=1 in cycle n+1 and with `rsp_valid`=0 when no lookup was presented. A miss returns `rsp_hit`=0, `rsp_fault`=0, and zero for `rsp_addr` and `rsp_mask`.
- R3: The granule code selects the page size: 0 and 3 select 4 KiB (12 offset bits), 1 selects 16 KiB (14 bits) and 2 selects 64 KiB (16 bits). A hit returns `rsp_addr` = aligned cached base + (request address AND page mask), and `rsp_mask` = page size − 1.
- R4: An entry hits only when the identifier is equal, the granule code is equal, and the request address aligned down to the granule equals the stored page. Any offset inside the page hits.
- R5: A write lookup (`lk_write`=1) that hits an entry stored with `fill_writable`=0 returns `rsp_hit`=1 and `rsp_fault`=1, with zero address and mask. A read of that entry, or a write to a writable entry, returns `rsp_fault`=0.
- R6: A fill with `fill_err`=1 stores nothing.
- R7: A successful fill whose tag is not present, arriving while all DEPTH entries are valid, first invalidates every entry and then stores the new one.
- R8: A fill whose tag (identifier, granule, aligned page) is already present overwrites that entry. No duplicate is created.
- R9: Invalidation kind 0 (all) and kind 3 (address only, no identifier) clear every entry.
- R10: Invalidation kind 1 clears every entry whose identifier equals `inv_asid` and leaves other identifiers intact.
- R11: Invalidation kind 2 clears the entry whose identifier equals `inv_asid` and whose page equals `inv_addr` aligned to that entry's own granule. Other pages are unaffected.
- R12: When an invalidation and a fill occur in the same cycle, the invalidation is applied after the fill, so a freshly filled entry that the invalidation matches is not kept.
- R13: `hit_count` increments on every lookup that hits, and `miss_count` on every lookup that misses. Both are unchanged in cycles with no lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_addr | input | VA_W | Lookup input address |
| lk_gran | input | 2 | Lookup granule code |
| lk_write | input | 1 | Lookup is a write |
| fill_valid | input | 1 | Walk result strobe |
| fill_err | input | 1 | Walk failed; store nothing |
| fill_asid | input | ASID_W | Fill identifier |
| fill_addr | input | VA_W | Fill input address (aligned internally) |
| fill_gran | input | 2 | Fill granule code |
| fill_base | input | VA_W | Translated base (aligned internally) |
| fill_writable | input | 1 | Page allows writes |
| inv_valid | input | 1 | Invalidation strobe |
| inv_kind | input | 2 | 0 all, 1 identifier, 2 identifier+page, 3 address only |
| inv_asid | input | ASID_W | Invalidation identifier |
| inv_addr | input | VA_W | Invalidation address |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_fault | output | 1 | Write permission fault on a hit |
| rsp_addr | output | VA_W | Translated address |
| rsp_mask | output | VA_W | Page offset mask |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |

## Verification
A corrupted valid bit, tag or base field is only visible through a lookup of the affected page. It appears one cycle after that lookup, as a wrong hit or miss, a wrong address or a spurious fault. The lookup counters then diverge from the expected tally at the same edge. The directed scenarios therefore follow every fill and invalidation with lookups of the affected pages and of neighbouring pages, identifiers and granules. A wrong clear or a missed clear is then caught on the very next response. The full-capacity case fills every entry and then probes entries at both ends before and after the overflowing fill.

// File: rtl/iotlb_pkg.sv
`timescale 1ns/1ps
package iotlb_pkg;

    typedef enum logic [1:0] {
        INV_ALL       = 2'd0,
        INV_ASID      = 2'd1,
        INV_PAGE      = 2'd2,
        INV_ADDR_ONLY = 2'd3
    } inv_e;

    // granule code -> number of in-page offset bits
    function automatic int unsigned page_bits(input logic [1:0] g);
        case (g)
            2'd1:    return 14;
            2'd2:    return 16;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/iotlb_tag_cmp.sv
`timescale 1ns/1ps
module iotlb_tag_cmp #(
    parameter int ASID_W = 16,
    parameter int VA_W   = 48
) (
    input  logic              e_valid,
    input  logic [ASID_W-1:0] e_asid,
    input  logic [VA_W-1:0]   e_page,
    input  logic [1:0]        e_gran,
    input  logic [ASID_W-1:0] q_asid,
    input  logic [VA_W-1:0]   q_page,
    input  logic [1:0]        q_gran,
    output logic              match
);
    assign match = e_valid && (e_asid == q_asid) && (e_gran == q_gran)
                   && (e_page == q_page);
endmodule

// File: rtl/iotlb_lsb_pick.sv
`timescale 1ns/1ps
module iotlb_lsb_pick #(
    parameter int DEPTH = 256,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] vec,
    output logic [IDX_W-1:0] idx,
    output logic             found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/iotlb_cache.sv
`timescale 1ns/1ps
module iotlb_cache
    import iotlb_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ASID_W = 16,
    parameter int VA_W   = 48,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_addr,
    input  logic [1:0]        lk_gran,
    input  logic              lk_write,
    input  logic              fill_valid,
    input  logic              fill_err,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VA_W-1:0]   fill_addr,
    input  logic [1:0]        fill_gran,
    input  logic [VA_W-1:0]   fill_base,
    input  logic              fill_writable,
    input  logic              inv_valid,
    input  logic [1:0]        inv_kind,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic [VA_W-1:0]   inv_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic [VA_W-1:0]   rsp_addr,
    output logic [VA_W-1:0]   rsp_mask,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic              v;
        logic [ASID_W-1:0] asid;
        logic [VA_W-1:0]   page;
        logic [1:0]        gran;
        logic [VA_W-1:0]   base;
        logic              wr;
    } ent_t;

    typedef struct packed {
        logic              rv;
        logic              hit;
        logic              fault;
        logic [VA_W-1:0]   addr;
        logic [VA_W-1:0]   mask;
        logic [CNT_W-1:0]  hcnt;
        logic [CNT_W-1:0]  mcnt;
    } out_t;

    function automatic logic [VA_W-1:0] pmask(input logic [1:0] g);
        return (VA_W'(1) << page_bits(g)) - VA_W'(1);
    endfunction

    ent_t [DEPTH-1:0] ent_q, ent_d;
    out_t             st_q, st_d;

    logic [VA_W-1:0]  lk_page, fill_page;
    logic [DEPTH-1:0] valid_vec, lk_hit_vec, fill_hit_vec;
    logic [IDX_W-1:0] lk_idx, fill_idx, free_idx;
    logic             lk_any, fill_any, free_any;
    ent_t             lk_e, new_e;

    assign lk_page   = lk_addr & ~pmask(lk_gran);
    assign fill_page = fill_addr & ~pmask(fill_gran);

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign valid_vec[i] = ent_q[i].v;

        iotlb_tag_cmp #(.ASID_W(ASID_W), .VA_W(VA_W)) u_lk_cmp (
            .e_valid (ent_q[i].v),
            .e_asid  (ent_q[i].asid),
            .e_page  (ent_q[i].page),
            .e_gran  (ent_q[i].gran),
            .q_asid  (lk_asid),
            .q_page  (lk_page),
            .q_gran  (lk_gran),
            .match   (lk_hit_vec[i])
        );

        iotlb_tag_cmp #(.ASID_W(ASID_W), .VA_W(VA_W)) u_fill_cmp (
            .e_valid (ent_q[i].v),
            .e_asid  (ent_q[i].asid),
            .e_page  (ent_q[i].page),
            .e_gran  (ent_q[i].gran),
            .q_asid  (fill_asid),
            .q_page  (fill_page),
            .q_gran  (fill_gran),
            .match   (fill_hit_vec[i])
        );
    end

    iotlb_lsb_pick #(.DEPTH(DEPTH)) u_lk_pick (
        .vec (lk_hit_vec), .idx (lk_idx), .found (lk_any)
    );
    iotlb_lsb_pick #(.DEPTH(DEPTH)) u_fill_pick (
        .vec (fill_hit_vec), .idx (fill_idx), .found (fill_any)
    );
    iotlb_lsb_pick #(.DEPTH(DEPTH)) u_free_pick (
        .vec (~valid_vec), .idx (free_idx), .found (free_any)
    );

    assign lk_e = ent_q[lk_idx];

    always_comb begin
        new_e.v    = 1'b1;
        new_e.asid = fill_asid;
        new_e.page = fill_page;
        new_e.gran = fill_gran;
        new_e.base = fill_base & ~pmask(fill_gran);
        new_e.wr   = fill_writable;
    end

    always_comb begin
        logic kill;
        ent_d = ent_q;
        st_d  = st_q;

        // lookup response, one cycle after the request
        st_d.rv    = lk_valid;
        st_d.hit   = 1'b0;
        st_d.fault = 1'b0;
        st_d.addr  = '0;
        st_d.mask  = '0;
        if (lk_valid) begin
            if (lk_any) begin
                st_d.hit  = 1'b1;
                st_d.hcnt = st_q.hcnt + CNT_W'(1);
                if (lk_write && !lk_e.wr) begin
                    st_d.fault = 1'b1;
                end else begin
                    st_d.addr = lk_e.base + (lk_addr & pmask(lk_e.gran));
                    st_d.mask = pmask(lk_e.gran);
                end
            end else begin
                st_d.mcnt = st_q.mcnt + CNT_W'(1);
            end
        end

        // fill: overwrite same tag, else first free slot, else flush all
        if (fill_valid && !fill_err) begin
            if (fill_any) begin
                ent_d[fill_idx] = new_e;
            end else if (free_any) begin
                ent_d[free_idx] = new_e;
            end else begin
                for (int j = 0; j < DEPTH; j++) ent_d[j].v = 1'b0;
                ent_d[0] = new_e;
            end
        end

        // invalidation applied last so it wins over a same-cycle fill
        if (inv_valid) begin
            for (int j = 0; j < DEPTH; j++) begin
                case (inv_e'(inv_kind))
                    INV_ASID: kill = (ent_d[j].asid == inv_asid);
                    INV_PAGE: kill = (ent_d[j].asid == inv_asid) &&
                                     (ent_d[j].page ==
                                      (inv_addr & ~pmask(ent_d[j].gran)));
                    default:  kill = 1'b1;
                endcase
                if (kill) ent_d[j].v = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
            st_q  <= '0;
        end else begin
            ent_q <= ent_d;
            st_q  <= st_d;
        end
    end

    assign rsp_valid  = st_q.rv;
    assign rsp_hit    = st_q.hit;
    assign rsp_fault  = st_q.fault;
    assign rsp_addr   = st_q.addr;
    assign rsp_mask   = st_q.mask;
    assign hit_count  = st_q.hcnt;
    assign miss_count = st_q.mcnt;

    // R8: fill replaces a present tag, so at most one entry can match
    a_r8_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec));

    // R5: a fault is only raised on a hit
    a_r5_fault_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_hit);

    // R2: a miss carries no address or mask
    a_r2_miss_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_addr == '0 && rsp_mask == '0));

    // R9: global and address-only invalidation leave nothing valid
    a_r9_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && (inv_kind == 2'd0 || inv_kind == 2'd3)) |=>
        (valid_vec == '0));

    // R13: counters hold when no lookup is presented
    a_r13_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> ($stable(hit_count) && $stable(miss_count)));

endmodule

// File: tb/tb_iotlb_cache.sv
`timescale 1ns/1ps
module tb_iotlb_cache;
    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [15:0] lk_asid = '0;
    logic [47:0] lk_addr = '0;
    logic [1:0]  lk_gran = '0;
    logic        lk_write = 1'b0;
    logic        fill_valid = 1'b0;
    logic        fill_err = 1'b0;
    logic [15:0] fill_asid = '0;
    logic [47:0] fill_addr = '0;
    logic [1:0]  fill_gran = '0;
    logic [47:0] fill_base = '0;
    logic        fill_writable = 1'b0;
    logic        inv_valid = 1'b0;
    logic [1:0]  inv_kind = '0;
    logic [15:0] inv_asid = '0;
    logic [47:0] inv_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [47:0] rsp_addr, rsp_mask;
    logic [31:0] hit_count, miss_count;

    int checks = 0;
    int errors = 0;
    int exp_hits = 0;
    int exp_miss = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    iotlb_cache #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_addr(lk_addr),
        .lk_gran(lk_gran), .lk_write(lk_write),
        .fill_valid(fill_valid), .fill_err(fill_err), .fill_asid(fill_asid),
        .fill_addr(fill_addr), .fill_gran(fill_gran), .fill_base(fill_base),
        .fill_writable(fill_writable),
        .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_asid(inv_asid),
        .inv_addr(inv_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_addr(rsp_addr), .rsp_mask(rsp_mask),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic lookup(input logic [15:0] a, input logic [47:0] va,
                          input logic [1:0] g, input logic w,
                          input logic exp_hit, input string req);
        lk_valid = 1'b1; lk_asid = a; lk_addr = va; lk_gran = g; lk_write = w;
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0;
        chk({req, " hit"}, {63'd0, rsp_hit}, {63'd0, exp_hit});
        if (exp_hit) exp_hits++; else exp_miss++;
    endtask

    task automatic fill(input logic [15:0] a, input logic [47:0] va,
                        input logic [1:0] g, input logic [47:0] base,
                        input logic w, input logic err);
        fill_valid = 1'b1; fill_asid = a; fill_addr = va; fill_gran = g;
        fill_base = base; fill_writable = w; fill_err = err;
        @(negedge clk);
        fill_valid = 1'b0; fill_err = 1'b0;
    endtask

    task automatic inval(input logic [1:0] k, input logic [15:0] a,
                         input logic [47:0] va);
        inv_valid = 1'b1; inv_kind = k; inv_asid = a; inv_addr = va;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        chk("R1 hit_count", {32'd0, hit_count}, 64'd0);
        chk("R1 miss_count", {32'd0, miss_count}, 64'd0);
        lookup(16'd1, 48'h1234_5000, 2'd0, 1'b0, 1'b0, "R1 empty lookup");
        chk("R2 miss addr", rsp_addr, 64'd0);
        chk("R2 miss mask", rsp_mask, 64'd0);
        chk("R2 valid after lookup", {63'd0, rsp_valid}, 64'd1);
    endtask

    task automatic t_granules();
        fill(16'd1, 48'h1234_5678, 2'd0, 48'hABCD_E123, 1'b1, 1'b0);
        chk("R2 idle no response", {63'd0, rsp_valid}, 64'd0);
        lookup(16'd1, 48'h1234_5ABC, 2'd0, 1'b0, 1'b1, "R3 4K");
        chk("R3 4K addr", rsp_addr, 64'hABCD_EABC);
        chk("R3 4K mask", rsp_mask, 64'hFFF);
        fill(16'd2, 48'h4_0000, 2'd1, 48'h8_0000, 1'b1, 1'b0);
        lookup(16'd2, 48'h4_3210, 2'd1, 1'b1, 1'b1, "R3 16K");
        chk("R3 16K addr", rsp_addr, 64'h8_3210);
        chk("R3 16K mask", rsp_mask, 64'h3FFF);
        fill(16'd3, 48'h7_0000_0000, 2'd2, 48'h123_0000, 1'b1, 1'b0);
        lookup(16'd3, 48'h7_0000_FEDC, 2'd2, 1'b0, 1'b1, "R3 64K");
        chk("R3 64K addr", rsp_addr, 64'h123_FEDC);
        chk("R3 64K mask", rsp_mask, 64'hFFFF);
        lookup(16'd1, 48'h1234_6000, 2'd0, 1'b0, 1'b0, "R4 next page");
        lookup(16'd9, 48'h1234_5000, 2'd0, 1'b0, 1'b0, "R4 other asid");
        lookup(16'd1, 48'h1234_5000, 2'd1, 1'b0, 1'b0, "R4 other granule");
        lookup(16'd1, 48'h1234_5FFF, 2'd0, 1'b0, 1'b1, "R4 page end");
        lookup(16'd1, 48'h1234_5FFF, 2'd3, 1'b0, 1'b0, "R4 code3 tag differs");
    endtask

    task automatic t_perm();
        fill(16'd4, 48'h9000, 2'd0, 48'h5000, 1'b0, 1'b0);
        lookup(16'd4, 48'h9010, 2'd0, 1'b0, 1'b1, "R5 read");
        chk("R5 read no fault", {63'd0, rsp_fault}, 64'd0);
        chk("R5 read addr", rsp_addr, 64'h5010);
        lookup(16'd4, 48'h9010, 2'd0, 1'b1, 1'b1, "R5 write");
        chk("R5 write fault", {63'd0, rsp_fault}, 64'd1);
        chk("R5 fault addr", rsp_addr, 64'd0);
    endtask

    task automatic t_fill_err();
        fill(16'd5, 48'hA000, 2'd0, 48'h7000, 1'b1, 1'b1);
        lookup(16'd5, 48'hA000, 2'd0, 1'b0, 1'b0, "R6 failed walk");
    endtask

    task automatic t_replace();
        fill(16'd6, 48'hB000, 2'd0, 48'h1000, 1'b1, 1'b0);
        fill(16'd6, 48'hB800, 2'd0, 48'h2000, 1'b1, 1'b0);
        lookup(16'd6, 48'hB004, 2'd0, 1'b0, 1'b1, "R8 replaced");
        chk("R8 new base", rsp_addr, 64'h2004);
    endtask

    task automatic t_inv_scopes();
        inval(2'd0, 16'd0, 48'd0);
        lookup(16'd1, 48'h1234_5000, 2'd0, 1'b0, 1'b0, "R9 all asid1");
        lookup(16'd3, 48'h7_0000_0000, 2'd2, 1'b0, 1'b0, "R9 all asid3");
        fill(16'd1, 48'h1234_5000, 2'd0, 48'h1000, 1'b1, 1'b0);
        inval(2'd3, 16'd77, 48'hDEAD_0000);
        lookup(16'd1, 48'h1234_5000, 2'd0, 1'b0, 1'b0, "R9 address-only");
        fill(16'd7, 48'h1000, 2'd0, 48'h1000, 1'b1, 1'b0);
        fill(16'd7, 48'h2000, 2'd0, 48'h2000, 1'b1, 1'b0);
        fill(16'd8, 48'h1000, 2'd0, 48'h3000, 1'b1, 1'b0);
        inval(2'd1, 16'd7, 48'd0);
        lookup(16'd7, 48'h1000, 2'd0, 1'b0, 1'b0, "R10 asid7 p1");
        lookup(16'd7, 48'h2000, 2'd0, 1'b0, 1'b0, "R10 asid7 p2");
        lookup(16'd8, 48'h1000, 2'd0, 1'b0, 1'b1, "R10 asid8 kept");
        fill(16'd10, 48'h3_0000, 2'd2, 48'h9_0000, 1'b1, 1'b0);
        fill(16'd10, 48'h5000, 2'd0, 48'h4000, 1'b1, 1'b0);
        fill(16'd11, 48'h3_0000, 2'd2, 48'hA_0000, 1'b1, 1'b0);
        inval(2'd2, 16'd10, 48'h3_ABCD);
        lookup(16'd10, 48'h3_0000, 2'd2, 1'b0, 1'b0, "R11 64K page cleared");
        lookup(16'd11, 48'h3_0000, 2'd2, 1'b0, 1'b1, "R11 other asid kept");
        inval(2'd2, 16'd10, 48'h6000);
        lookup(16'd10, 48'h5000, 2'd0, 1'b0, 1'b1, "R11 other page kept");
    endtask

    task automatic t_same_cycle();
        fill_valid = 1'b1; fill_asid = 16'd12; fill_addr = 48'hC000;
        fill_gran = 2'd0; fill_base = 48'h6000; fill_writable = 1'b1; fill_err = 1'b0;
        inv_valid = 1'b1; inv_kind = 2'd2; inv_asid = 16'd12; inv_addr = 48'hC123;
        @(negedge clk);
        fill_valid = 1'b0; inv_valid = 1'b0;
        lookup(16'd12, 48'hC000, 2'd0, 1'b0, 1'b0, "R12 inv wins");
        fill_valid = 1'b1; fill_asid = 16'd13;
        inv_valid = 1'b1; inv_kind = 2'd1; inv_asid = 16'd14;
        @(negedge clk);
        fill_valid = 1'b0; inv_valid = 1'b0;
        lookup(16'd13, 48'hC000, 2'd0, 1'b0, 1'b1, "R12 unrelated inv");
    endtask

    task automatic t_full();
        inval(2'd0, 16'd0, 48'd0);
        for (int i = 0; i < DEPTH; i++)
            fill(16'd20, 48'(i) << 12, 2'd0, 48'(i + 1) << 16, 1'b1, 1'b0);
        lookup(16'd20, 48'h0, 2'd0, 1'b0, 1'b1, "R7 first before");
        lookup(16'd20, 48'(DEPTH - 1) << 12, 2'd0, 1'b0, 1'b1, "R7 last before");
        fill(16'd20, 48'(DEPTH) << 12, 2'd0, 48'h77_0000, 1'b1, 1'b0);
        lookup(16'd20, 48'h0, 2'd0, 1'b0, 1'b0, "R7 first flushed");
        lookup(16'd20, 48'd100 << 12, 2'd0, 1'b0, 1'b0, "R7 middle flushed");
        lookup(16'd20, (48'(DEPTH) << 12) | 48'h42, 2'd0, 1'b0, 1'b1, "R7 new kept");
        chk("R7 new addr", rsp_addr, 64'h77_0042);
    endtask

    task automatic t_counters();
        @(negedge clk);
        chk("R13 hit_count", {32'd0, hit_count}, 64'(exp_hits));
        chk("R13 miss_count", {32'd0, miss_count}, 64'(exp_miss));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_granules();
        t_perm();
        t_fill_err();
        t_replace();
        t_inv_scopes();
        t_same_cycle();
        t_full();
        t_counters();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule